// File: doc/BRIEF.md
# Scaled Fractional-Step System Counter

This block is a free-running 64-bit system counter. Each pulse on the tick input stands for one period of the counter's operating frequency. On a tick the counter either steps by exactly one or, when scaling is switched on, adds a programmable scale value. The scale value is an unsigned fixed-point number with 8 integer bits and 24 fractional bits. A hidden 24-bit fraction register sits below the visible count, so partial steps build up across ticks and carry into the integer count.

Software reaches the block through a small word-wide register port. A write is a single-cycle strobe. A read is combinational on the read address. The control word holds:

- the run bit,
- the scaling bit,
- a sticky read-only flag that marks the count as untrustworthy.

The flag is raised when the scale value is rewritten while the counter is running. The count itself is readable as two 32-bit halves. It can be loaded only while the counter is stopped.

Top module: `scaled_counter`

## Requirements
- R1: After a synchronous active-low reset:
  - the control word reads 0,
  - the scale register reads 0x0100_0000 (1.0),
  - the count reads 0 at both halves.
- R2: While the run bit (control bit 0) is 0, ticks are ignored, and the count and the hidden fraction hold their values.
- R3: While running with the scaling bit (control bit 1) at 0, each tick increments the count by exactly 1, including across the 32-bit half boundary, and leaves the fraction untouched.
- R4: While running with scaling on, each tick adds the 32-bit scale value (integer in bits 31:24, fraction in bits 23:0) to the concatenation of count and fraction. The fraction's carry increments the count, so the count advances by the integer part or by the integer part plus one.
- R5: The scale register at byte offset 0x10 is readable and writable as a full 32-bit word.
- R6: A write to offset 0x10 while the run bit is 1 sets the invalid flag at control bit 2. The flag stays set until reset. Software writes to the control word cannot change it.
- R7: Offsets 0x08 and 0x0C read the low and high 32 bits of the count. Writes to them load those bits only while the run bit is 0, and are ignored while it is 1.
- R8: The control word is at offset 0x00. Writes set bits 0 and 1 from write-data bits 0 and 1. Unused control bits and unmapped offsets read as 0.
- R9: The count wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One pulse per counter period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |
| count_o | output | 64 | Current count value |

## Verification
The bound checker watches these properties on every cycle:

- a stopped counter holds its count unless it is loaded,
- an unscaled running tick adds exactly one,
- a scaled tick advances the count by the integer part of the scale or one more,
- a running counter does not move without a tick,
- the invalid flag is raised by a write to the scale register while running, and never falls before reset.

Only the bench's behavioural model, compared on every clock, can show the following:

- fractional carries accumulating correctly across long tick runs, such as quarter and one-and-a-half steps,
- loads of the count halves,
- the 64-bit wrap,
- the register read-back values.

// File: rtl/scnt_pkg.sv
// Shared constants for the scaled system counter: register byte offsets
// and control-word bit positions. Assumes a 5-bit byte address.
package scnt_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_CNTLO = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_CNTHI = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_SCALE = 5'h10;
    localparam int BIT_RUN   = 0;
    localparam int BIT_SCALE = 1;
    localparam int BIT_BAD   = 2;
endpackage

// File: rtl/scnt_regs.sv
// Control and scale registers. Holds the run bit, the scaling bit, the
// sticky invalid flag and the scale value. Produces gated load strobes for
// the count halves, which are legal only while stopped.
// Assumes single-cycle write strobes.
module scnt_regs
    import scnt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] SCALE_RST = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              run_o,
    output logic              scl_en_o,
    output logic              bad_o,
    output logic [DATA_W-1:0] scale_o,
    output logic              ld_lo_o,
    output logic              ld_hi_o
);
    logic wr_ctrl, wr_scale;

    // Decode write targets.
    always_comb begin
        wr_ctrl  = wr_en_i && (wr_addr_i == OFF_CTRL);
        wr_scale = wr_en_i && (wr_addr_i == OFF_SCALE);
        ld_lo_o  = wr_en_i && (wr_addr_i == OFF_CNTLO) && !run_o;
        ld_hi_o  = wr_en_i && (wr_addr_i == OFF_CNTHI) && !run_o;
    end

    // Control bits and sticky flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o    <= 1'b0;
            scl_en_o <= 1'b0;
            bad_o    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                run_o    <= wr_data_i[BIT_RUN];
                scl_en_o <= wr_data_i[BIT_SCALE];
            end
            if (wr_scale && run_o)
                bad_o <= 1'b1;
        end
    end

    // Scale register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scale_o <= SCALE_RST;
        else if (wr_scale)
            scale_o <= wr_data_i;
    end
endmodule

// File: rtl/scnt_accum.sv
// Count datapath: a CNT_W-bit integer count above a FRAC_W-bit hidden
// fraction. A scaled tick adds the fixed-point scale to {count, fraction}.
// An unscaled tick adds one to the count. Count halves load from the
// register port. Assumes CNT_W == 2*DATA_W and that loads arrive only
// while stopped (the load strobes are gated upstream).
module scnt_accum #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64,
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              scl_en_i,
    input  logic [DATA_W-1:0] scale_i,
    input  logic              ld_lo_i,
    input  logic              ld_hi_i,
    input  logic [DATA_W-1:0] ld_data_i,
    output logic [CNT_W-1:0]  count_o
);
    localparam int SUM_W = CNT_W + FRAC_W;
    localparam int PAD_W = SUM_W - DATA_W;

    logic [FRAC_W-1:0] frac_q;
    logic [SUM_W-1:0]  scaled_sum;

    // Fixed-point sum of {count, fraction} and the zero-extended scale.
    always_comb scaled_sum = {count_o, frac_q} + {{PAD_W{1'b0}}, scale_i};

    // Count and fraction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
            frac_q  <= '0;
        end else if (step_i) begin
            if (scl_en_i)
                {count_o, frac_q} <= scaled_sum;
            else
                count_o <= count_o + 1'b1;
        end else begin
            if (ld_lo_i) count_o[DATA_W-1:0]     <= ld_data_i;
            if (ld_hi_i) count_o[CNT_W-1:DATA_W] <= ld_data_i;
        end
    end
endmodule

// File: rtl/scaled_counter.sv
// Top level of the scaled system counter. Joins the register block and
// the count datapath and provides the combinational read mux.
// Assumes one tick pulse per counter period.
module scaled_counter
    import scnt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64,
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [4:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [4:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  count_o
);
    logic              run, scl_en, bad, ld_lo, ld_hi, step;
    logic [DATA_W-1:0] scale;

    scnt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .run_o(run), .scl_en_o(scl_en), .bad_o(bad),
        .scale_o(scale), .ld_lo_o(ld_lo), .ld_hi_o(ld_hi)
    );

    // A tick counts only while running.
    always_comb step = tick_i && run;

    scnt_accum #(.DATA_W(DATA_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .step_i(step), .scl_en_i(scl_en),
        .scale_i(scale), .ld_lo_i(ld_lo), .ld_hi_i(ld_hi),
        .ld_data_i(wr_data_i), .count_o(count_o)
    );

    // Read mux over the mapped offsets.
    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            OFF_CTRL: begin
                rd_data_o[BIT_RUN]   = run;
                rd_data_o[BIT_SCALE] = scl_en;
                rd_data_o[BIT_BAD]   = bad;
            end
            OFF_CNTLO: rd_data_o = count_o[DATA_W-1:0];
            OFF_CNTHI: rd_data_o = count_o[CNT_W-1:DATA_W];
            OFF_SCALE: rd_data_o = scale;
            default:   rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/scaled_counter_checker.sv
// Temporal checks for the scaled counter, bound to the top module.
// Assumes the default 8.24 scale format and a 64-bit count.
module scaled_counter_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_i,
    input logic        wr_en_i,
    input logic [4:0]  wr_addr_i,
    input logic        run,
    input logic        scl_en,
    input logic        bad,
    input logic [31:0] scale,
    input logic [63:0] count_o
);
    logic cnt_load;
    assign cnt_load = wr_en_i && (wr_addr_i == 5'h08 || wr_addr_i == 5'h0C);

    // R2: a stopped counter holds unless a count half is loaded.
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_load) |=> $stable(count_o));

    // R3: an unscaled running tick adds exactly one.
    p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !scl_en && tick_i && !bad) |=> (count_o == $past(count_o) + 64'd1));

    // R4: a scaled tick advances by the integer part, or by one more on a carry.
    p_scaled_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && scl_en && tick_i && !bad) |=>
        ((count_o - $past(count_o) == {56'd0, $past(scale[31:24])}) ||
         (count_o - $past(count_o) == {56'd0, $past(scale[31:24])} + 64'd1)));

    // R7: a running counter without a tick ignores loads and holds.
    p_no_load_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick_i && !bad) |=> $stable(count_o));

    // R6: a scale write while running raises the flag.
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en_i && wr_addr_i == 5'h10) |=> bad);

    // R6: the flag is sticky until reset.
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> bad);
endmodule

bind scaled_counter scaled_counter_checker u_checker (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .run(run), .scl_en(scl_en), .bad(bad),
    .scale(scale), .count_o(count_o)
);

// File: tb/scaled_counter_bench.sv
`timescale 1ns/1ps
module scaled_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [4:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [4:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic [63:0] count_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    logic [63:0] m_cnt;
    logic [23:0] m_frac;
    logic [31:0] m_scale;
    bit m_run, m_scl, m_bad;

    always #2.5 clk = ~clk;

    scaled_counter u_scaled_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .count_o(count_o)
    );

    // Reference model, updated from the pre-edge state at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_frac = 0; m_scale = 32'h0100_0000;
            m_run = 0; m_scl = 0; m_bad = 0;
        end else begin
            bit o_run;
            o_run = m_run;
            if (tick_i && o_run) begin
                if (m_scl) begin
                    logic [87:0] acc;
                    acc = {m_cnt, m_frac} + {56'd0, m_scale};
                    m_cnt = acc[87:24]; m_frac = acc[23:0];
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (wr_en_i) begin
                case (wr_addr_i)
                    5'h00: begin m_run = wr_data_i[0]; m_scl = wr_data_i[1]; end
                    5'h08: if (!o_run) m_cnt[31:0] = wr_data_i;
                    5'h0C: if (!o_run) m_cnt[63:32] = wr_data_i;
                    5'h10: begin m_scale = wr_data_i; if (o_run) m_bad = 1; end
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison of the count (don't-care once flagged invalid).
    always @(negedge clk) begin
        if (rst_n && !m_bad) begin
            checks++;
            if (count_o !== m_cnt) begin
                fails++;
                $display("FAIL R2 R3 R4 R9 count: actual %h expected %h", count_o, m_cnt);
            end
        end
    end

    task automatic check_rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        rd_addr_i = a;
        #1;
        checks++;
        if (rd_data_o !== exp) begin
            fails++;
            $display("FAIL %s read %h: actual %h expected %h", req, a, rd_data_o, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            tick_i = 1; @(negedge clk); tick_i = 0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 and R8: reset values, unused offset reads zero.
        check_rd(5'h00, 32'h0, "R1");
        check_rd(5'h10, 32'h0100_0000, "R1");
        check_rd(5'h08, 32'h0, "R1");
        check_rd(5'h0C, 32'h0, "R1");
        check_rd(5'h04, 32'h0, "R8");
        // R2: ticks while stopped are ignored.
        ticks(5, 0);
        check_rd(5'h08, 32'h0, "R2");
        // R7: load count while stopped.
        wr(5'h08, 32'hFFFF_FFF0);
        wr(5'h0C, 32'h0000_0000);
        check_rd(5'h08, 32'hFFFF_FFF0, "R7");
        // R3: unscaled steps across the 32-bit half boundary; R8 control read.
        wr(5'h00, 32'hFFFF_FFF9);
        check_rd(5'h00, 32'h1, "R8");
        ticks(20, 1);
        check_rd(5'h0C, 32'h1, "R3");
        check_rd(5'h08, 32'h4, "R3");
        // R7: load ignored while running.
        wr(5'h08, 32'h1234_5678);
        check_rd(5'h08, 32'h4, "R7");
        // R5 and R4: 1.5 steps, carry every other tick.
        wr(5'h00, 32'h0);
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h0);
        wr(5'h10, 32'h0180_0000);
        check_rd(5'h10, 32'h0180_0000, "R5");
        wr(5'h00, 32'h3);
        ticks(2, 0);
        check_rd(5'h08, 32'h3, "R4");
        ticks(7, 2);
        // R4: 0.25 steps, four ticks per count.
        wr(5'h00, 32'h0);
        wr(5'h10, 32'h0040_0000);
        wr(5'h00, 32'h3);
        ticks(16, 0);
        // R9: wrap at 2^64 with scale 2.0.
        wr(5'h00, 32'h0);
        wr(5'h08, 32'hFFFF_FFFC);
        wr(5'h0C, 32'hFFFF_FFFF);
        wr(5'h10, 32'h0200_0000);
        wr(5'h00, 32'h3);
        ticks(3, 0);
        check_rd(5'h0C, 32'h0, "R9");
        check_rd(5'h08, 32'h2, "R9");
        // R6: scale write while running sets the sticky flag.
        wr(5'h10, 32'h0300_0000);
        check_rd(5'h00, 32'h7, "R6");
        wr(5'h00, 32'h0);
        check_rd(5'h00, 32'h4, "R6");
        ticks(3, 1);
        check_rd(5'h00, 32'h4, "R6");
        // R6 and R1: only reset clears it.
        do_reset();
        check_rd(5'h00, 32'h0, "R6");
        check_rd(5'h08, 32'h0, "R1");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule